// File: doc/BRIEF.md
# Encoder Block-Load Handshake Controller

This controller sits in front of a serial-input turbo encoder and governs how one block of input bits is written into the encoder's block buffer. A block starts with a start strobe, optionally qualified by a sample-valid strobe. On that edge the controller latches a 4-bit size code, converts it to a bit count with a small lookup, and takes the first data bit. It then accepts qualified bits until the block holds that many. Every accepted bit is turned into a buffer write with a zero-based address. A done pulse marks the final bit.

Two ready outputs describe the handshake. `start_ready` says a new block may begin. `data_ready` says bits are being taken into the current block. After the last bit, the controller models the downstream encoder as busy for the block length plus a fixed termination count. During that time both ready outputs are low. After it, `start_ready` returns high. A compile-time option selects whether the sample-valid strobe exists. Without it, every clock of a load is a sample.

Top module: `blkload_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `start_ready`=1, `data_ready`=0, `buf_we`=0, `blk_done`=0 and `code_err`=0.
- R2: A start event is `blk_start`=1 on a rising edge while `start_ready`=1, together with `smp_vld`=1 when USE_VLD=1. From the next cycle, `start_ready`=0 and `data_ready`=1. If `blk_start`=1 with `smp_vld`=0 and USE_VLD=1, there is no start: `start_ready` stays 1.
- R3: The start edge also captures the first bit. The next cycle shows `buf_we`=1, `buf_addr`=0 and `buf_wdata` equal to `bit_in` at that edge.
- R4: The size code selects the block length N: code 0→122, 1→250, 2→506, 3→762, 4→1018, 5→1530, 6→2042, 7→3066, 8→4090, 9→6138, 10→8186, 11→12282, 12→16378. The code is sampled only on the start edge. Exactly N buffer writes happen per block.
- R5: During a load, each edge with `smp_vld`=1 (or every edge when USE_VLD=0) writes one bit. After the N-th write, `data_ready` is 0 and `blk_done` is high for exactly that one write cycle. Edges with `smp_vld`=0 write nothing.
- R6: After the edge that takes the N-th bit, `start_ready` stays 0 for N+TERM_CYCLES cycles, with `data_ready`=0, and then returns to 1.
- R7: Codes 13 to 15 load a block of code 0's length (122). They set `code_err`=1, which stays set until reset.
- R8: Within a block, write addresses run 0,1,…,N-1 with no gaps. Each `buf_wdata` equals `bit_in` on the edge that accepted it.
- R9: A `blk_start` while `start_ready`=0 is ignored. It neither restarts the address sequence nor changes the block length.
- R10: With USE_VLD=0 the block loads on N consecutive clocks, and `smp_vld` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | 1 | Start strobe for a new block |
| smp_vld | input | 1 | Sample-valid strobe (only used when USE_VLD=1) |
| size_code | input | 4 | Block-size code, sampled on the start event |
| bit_in | input | 1 | Serial input bit |
| start_ready | output | 1 | High when a new block may start |
| data_ready | output | 1 | High while bits of a block are accepted |
| buf_we | output | 1 | Block buffer write enable |
| buf_addr | output | LEN_W | Zero-based block buffer write address |
| buf_wdata | output | 1 | Bit written to the block buffer |
| blk_done | output | 1 | One-cycle pulse with the final write of a block |
| code_err | output | 1 | Sticky flag: an illegal size code was latched |

## Verification
The assertions assume that `rst` is high from time zero. They make no assumption about `blk_start`, `smp_vld` or `size_code`: a start may arrive in any cycle and any code may appear, because illegal codes and starts during a load have defined outcomes. The stimulus therefore pulses `blk_start` at random inside loads and busy periods, uses sample-valid densities from sparse to full, and applies an illegal code. Two instances share one input stream, one with the sample-valid option and one without, and each is tracked by its own behavioural model.

// File: rtl/blkload_pkg.sv
package blkload_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_BUSY = 2'd2
  } ld_state_e;

  localparam int NUM_CODES = 13;

  // Block length in bits for a legal size code.
  function automatic int unsigned code_len(input logic [3:0] code);
    case (code)
      4'd0:    return 122;
      4'd1:    return 250;
      4'd2:    return 506;
      4'd3:    return 762;
      4'd4:    return 1018;
      4'd5:    return 1530;
      4'd6:    return 2042;
      4'd7:    return 3066;
      4'd8:    return 4090;
      4'd9:    return 6138;
      4'd10:   return 8186;
      4'd11:   return 12282;
      4'd12:   return 16378;
      default: return 122;
    endcase
  endfunction

endpackage

// File: rtl/blkload_size_map.sv
module blkload_size_map #(
  parameter int LEN_W = 15
) (
  input  logic [3:0]       code,
  output logic [LEN_W-1:0] len,
  output logic             illegal
);
  import blkload_pkg::*;

  logic [3:0] eff_code;

  always_comb begin
    illegal  = (code >= 4'(NUM_CODES));
    eff_code = illegal ? 4'd0 : code;
    len      = LEN_W'(code_len(eff_code));
  end

endmodule

// File: rtl/blkload_sample_ctr.sv
module blkload_sample_ctr #(
  parameter int LEN_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step,
  output logic [LEN_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= LEN_W'(1);
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/blkload_busy_tmr.sv
module blkload_busy_tmr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expire
);

  logic [W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (run && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expire = run && (remain == W'(1));

endmodule

// File: rtl/blkload_ctrl.sv
module blkload_ctrl #(
  parameter bit USE_VLD     = 1'b1,
  parameter int LEN_W       = 15,
  parameter int TERM_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_start,
  input  logic             smp_vld,
  input  logic [3:0]       size_code,
  input  logic             bit_in,
  output logic             start_ready,
  output logic             data_ready,
  output logic             buf_we,
  output logic [LEN_W-1:0] buf_addr,
  output logic             buf_wdata,
  output logic             blk_done,
  output logic             code_err
);
  import blkload_pkg::*;

  localparam int BUSY_W = LEN_W + 1;

  ld_state_e        state;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] map_len;
  logic             map_illegal;
  logic [LEN_W-1:0] smp_cnt;
  logic             qual;
  logic             start_evt;
  logic             take;
  logic             last;
  logic             busy_expire;
  logic [BUSY_W-1:0] busy_len;

  // Without the strobe option every clock is a sample.
  assign qual      = smp_vld | (USE_VLD == 1'b0);
  assign start_evt = (state == ST_IDLE) && blk_start && qual;
  assign take      = (state == ST_LOAD) && qual;
  assign last      = take && (smp_cnt == len_q - 1'b1);
  assign busy_len  = BUSY_W'(len_q) + BUSY_W'(TERM_CYCLES);

  blkload_size_map #(.LEN_W(LEN_W)) u_map (
    .code    (size_code),
    .len     (map_len),
    .illegal (map_illegal)
  );

  blkload_sample_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .start (start_evt),
    .step  (take),
    .cnt   (smp_cnt)
  );

  blkload_busy_tmr #(.W(BUSY_W)) u_busy (
    .clk      (clk),
    .rst      (rst),
    .load     (last),
    .load_val (busy_len),
    .run      (state == ST_BUSY),
    .expire   (busy_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      len_q       <= '0;
      start_ready <= 1'b1;
      data_ready  <= 1'b0;
      buf_we      <= 1'b0;
      buf_addr    <= '0;
      buf_wdata   <= 1'b0;
      blk_done    <= 1'b0;
      code_err    <= 1'b0;
    end else begin
      buf_we   <= 1'b0;
      blk_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_evt) begin
            len_q       <= map_len;
            code_err    <= code_err | map_illegal;
            buf_we      <= 1'b1;
            buf_addr    <= '0;
            buf_wdata   <= bit_in;
            start_ready <= 1'b0;
            data_ready  <= 1'b1;
            state       <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (take) begin
            buf_we    <= 1'b1;
            buf_addr  <= smp_cnt;
            buf_wdata <= bit_in;
            if (last) begin
              blk_done   <= 1'b1;
              data_ready <= 1'b0;
              state      <= ST_BUSY;
            end
          end
        end
        ST_BUSY: begin
          if (busy_expire) begin
            start_ready <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        default: begin
          state       <= ST_IDLE;
          start_ready <= 1'b1;
          data_ready  <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/blkload_ctrl_chk.sv
module blkload_ctrl_chk #(
  parameter bit USE_VLD = 1'b1,
  parameter int LEN_W   = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             blk_start,
  input logic             smp_vld,
  input logic             start_ready,
  input logic             data_ready,
  input logic             buf_we,
  input logic [LEN_W-1:0] buf_addr,
  input logic             blk_done,
  input logic             code_err
);

  logic [LEN_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (rst) prev_addr <= '0;
    else if (buf_we) prev_addr <= buf_addr;
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (start_ready && !data_ready && !buf_we && !blk_done && !code_err));

  // R2 and R3
  a_r3_start_first_write: assert property (@(posedge clk) disable iff (rst)
    (start_ready && blk_start && (smp_vld || (USE_VLD == 1'b0)))
      |=> (buf_we && buf_addr == '0 && data_ready && !start_ready));

  // R5
  a_r5_ready_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(start_ready && data_ready));

  // R5
  a_r5_done_with_last: assert property (@(posedge clk) disable iff (rst)
    blk_done |-> (buf_we && !data_ready && !start_ready));

  // R8
  a_r8_addr_contiguous: assert property (@(posedge clk) disable iff (rst)
    (buf_we && buf_addr != '0) |-> (buf_addr == LEN_W'(prev_addr + 1'b1)));

  // R8
  a_r8_write_when_ready: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> $past(start_ready || data_ready));

  // R9
  a_r9_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
    (!start_ready && !data_ready && blk_start) |=> !data_ready);

  // R7
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    code_err |=> code_err);

endmodule

bind blkload_ctrl blkload_ctrl_chk #(.USE_VLD(USE_VLD), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .blk_start   (blk_start),
  .smp_vld     (smp_vld),
  .start_ready (start_ready),
  .data_ready  (data_ready),
  .buf_we      (buf_we),
  .buf_addr    (buf_addr),
  .blk_done    (blk_done),
  .code_err    (code_err)
);

// File: tb/blkload_ctrl_bench.sv
module blkload_ref #(
  parameter bit USE_VLD = 1'b1,
  parameter int TERM    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       blk_start,
  input  logic       smp_vld,
  input  logic [3:0] size_code,
  input  logic       bit_in,
  output logic       e_start,
  output logic       e_data,
  output logic       e_we,
  output int         e_addr,
  output logic       e_wdata,
  output logic       e_done,
  output logic       e_err,
  output logic       e_ignored
);
  int phase;   // 0 idle, 1 loading, 2 busy
  int n_bits;
  int taken;
  int busy_left;

  function automatic int len_of(input int code);
    int tbl[13] = '{122, 250, 506, 762, 1018, 1530, 2042, 3066, 4090,
                    6138, 8186, 12282, 16378};
    if (code > 12) return tbl[0];
    return tbl[code];
  endfunction

  always @(posedge clk) begin
    logic q;
    q = USE_VLD ? smp_vld : 1'b1;
    if (rst) begin
      phase = 0; e_start = 1; e_data = 0; e_we = 0; e_done = 0;
      e_err = 0; e_addr = 0; e_wdata = 0; e_ignored = 0;
    end else begin
      e_we = 0; e_done = 0;
      e_ignored = blk_start && (phase != 0);
      if (phase == 0) begin
        if (blk_start && q) begin
          n_bits = len_of(int'(size_code));
          if (size_code > 4'd12) e_err = 1;
          e_we = 1; e_addr = 0; e_wdata = bit_in; taken = 1;
          phase = 1; e_start = 0; e_data = 1;
        end
      end else if (phase == 1) begin
        if (q) begin
          e_we = 1; e_addr = taken; e_wdata = bit_in; taken++;
          if (taken == n_bits) begin
            e_done = 1; e_data = 0; phase = 2; busy_left = n_bits + TERM;
          end
        end
      end else begin
        busy_left--;
        if (busy_left == 0) begin
          phase = 0; e_start = 1;
        end
      end
    end
  end
endmodule

module blkload_ctrl_bench;
  localparam int LEN_W = 15;
  localparam int TERM  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic blk_start = 1'b0;
  logic smp_vld = 1'b0;
  logic [3:0] size_code = 4'd0;
  logic bit_in = 1'b0;

  always #4 clk = ~clk;

  logic m_start, m_data, m_we, m_wdata, m_done, m_err;
  logic [LEN_W-1:0] m_addr;
  logic f_start, f_data, f_we, f_wdata, f_done, f_err;
  logic [LEN_W-1:0] f_addr;

  blkload_ctrl #(.USE_VLD(1'b1), .LEN_W(LEN_W), .TERM_CYCLES(TERM)) u_blkload_ctrl (
    .clk(clk), .rst(rst), .blk_start(blk_start), .smp_vld(smp_vld),
    .size_code(size_code), .bit_in(bit_in), .start_ready(m_start),
    .data_ready(m_data), .buf_we(m_we), .buf_addr(m_addr),
    .buf_wdata(m_wdata), .blk_done(m_done), .code_err(m_err));

  blkload_ctrl #(.USE_VLD(1'b0), .LEN_W(LEN_W), .TERM_CYCLES(TERM)) u_blkload_ctrl_free (
    .clk(clk), .rst(rst), .blk_start(blk_start), .smp_vld(smp_vld),
    .size_code(size_code), .bit_in(bit_in), .start_ready(f_start),
    .data_ready(f_data), .buf_we(f_we), .buf_addr(f_addr),
    .buf_wdata(f_wdata), .blk_done(f_done), .code_err(f_err));

  logic me_start, me_data, me_we, me_wdata, me_done, me_err, me_ign;
  int   me_addr;
  logic fe_start, fe_data, fe_we, fe_wdata, fe_done, fe_err, fe_ign;
  int   fe_addr;

  blkload_ref #(.USE_VLD(1'b1), .TERM(TERM)) u_ref_m (
    .clk(clk), .rst(rst), .blk_start(blk_start), .smp_vld(smp_vld),
    .size_code(size_code), .bit_in(bit_in), .e_start(me_start),
    .e_data(me_data), .e_we(me_we), .e_addr(me_addr), .e_wdata(me_wdata),
    .e_done(me_done), .e_err(me_err), .e_ignored(me_ign));

  blkload_ref #(.USE_VLD(1'b0), .TERM(TERM)) u_ref_f (
    .clk(clk), .rst(rst), .blk_start(blk_start), .smp_vld(smp_vld),
    .size_code(size_code), .bit_in(bit_in), .e_start(fe_start),
    .e_data(fe_data), .e_we(fe_we), .e_addr(fe_addr), .e_wdata(fe_wdata),
    .e_done(fe_done), .e_err(fe_err), .e_ignored(fe_ign));

  int total = 0;
  int bad = 0;
  bit cmp_on = 0;
  bit finished = 0;
  int cycles = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int len_of(input int code);
    int tbl[13] = '{122, 250, 506, 762, 1018, 1530, 2042, 3066, 4090,
                    6138, 8186, 12282, 16378};
    if (code > 12) return tbl[0];
    return tbl[code];
  endfunction

  // Per-cycle comparison against the reference models.
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R6", "main start_ready", int'(m_start), int'(me_start));
      chk("R5", "main data_ready", int'(m_data), int'(me_data));
      chk("R8", "main buf_we", int'(m_we), int'(me_we));
      chk("R5", "main blk_done", int'(m_done), int'(me_done));
      chk("R7", "main code_err", int'(m_err), int'(me_err));
      if (me_we) begin
        chk(me_ign ? "R9" : "R8", "main buf_addr", int'(m_addr), me_addr);
        chk("R3", "main buf_wdata", int'(m_wdata), int'(me_wdata));
      end
      chk("R10", "free start_ready", int'(f_start), int'(fe_start));
      chk("R10", "free data_ready", int'(f_data), int'(fe_data));
      chk("R10", "free buf_we", int'(f_we), int'(fe_we));
      chk("R10", "free blk_done", int'(f_done), int'(fe_done));
      chk("R7", "free code_err", int'(f_err), int'(fe_err));
      if (fe_we) begin
        chk(fe_ign ? "R9" : "R10", "free buf_addr", int'(f_addr), fe_addr);
        chk("R10", "free buf_wdata", int'(f_wdata), int'(fe_wdata));
      end
    end
  end

  task automatic wait_both_idle();
    do @(negedge clk); while (!(m_start && f_start));
  endtask

  // Runs one block on the main instance with random sample gaps and start noise.
  task automatic run_block(input int code, input int vld_pct, input bit noise);
    int writes;
    wait_both_idle();
    size_code = 4'(code);
    blk_start = 1'b1;
    smp_vld   = 1'b1;
    bit_in    = 1'($urandom);
    @(negedge clk);
    chk("R2", "start_ready after start", int'(m_start), 0);
    chk("R2", "data_ready after start", int'(m_data), 1);
    chk("R3", "first write address", int'(m_addr), 0);
    writes = 0;
    while (!m_start) begin
      writes += int'(m_we);
      smp_vld   = (($urandom % 100) < vld_pct);
      bit_in    = 1'($urandom);
      blk_start = noise && (($urandom % 40) == 0);
      @(negedge clk);
    end
    blk_start = 1'b0;
    chk("R4", "writes in block", writes, len_of(code));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "start_ready", int'(m_start), 1);
    chk("R1", "data_ready", int'(m_data), 0);
    chk("R1", "buf_we", int'(m_we), 0);
    chk("R1", "blk_done", int'(m_done), 0);
    chk("R1", "code_err", int'(m_err), 0);
    cmp_on = 1;

    // R2: start without sample-valid is not a start for the strobed instance.
    blk_start = 1'b1;
    smp_vld   = 1'b0;
    @(negedge clk);
    blk_start = 1'b0;
    chk("R2", "no start without smp_vld", int'(m_start), 1);
    chk("R2", "no load without smp_vld", int'(m_data), 0);

    run_block(0, 70, 1'b1);
    run_block(13, 60, 1'b1);
    chk("R7", "code_err after illegal code", int'(m_err), 1);
    run_block(1, 100, 1'b0);
    chk("R7", "code_err stays set", int'(m_err), 1);

    // R10: free-running instance loads on consecutive clocks, smp_vld low.
    begin
      int writes;
      int span;
      wait_both_idle();
      size_code = 4'd2;
      blk_start = 1'b1;
      smp_vld   = 1'b0;
      @(negedge clk);
      blk_start = 1'b0;
      writes = 0;
      span = 0;
      while (!f_done && span < 5000) begin
        writes += int'(f_we);
        span++;
        bit_in = 1'($urandom);
        @(negedge clk);
      end
      writes += int'(f_we);
      span++;
      chk("R10", "free writes", writes, len_of(2));
      chk("R10", "free load cycles", span, len_of(2));
      chk("R2", "main idle while smp_vld low", int'(m_start), 1);
    end

    run_block(12, 80, 1'b1);
    wait_both_idle();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule